// File: doc/BRIEF.md
# Serial Command Port Slave

This block lets an external controller load registers over a three-wire synchronous serial link. The controller owns the serial clock. The block runs on a much faster system clock and samples both the serial clock and the serial data on a periodic enable. It detects rising edges of the sampled serial clock and assembles 32-bit command words from them.

Each finished word is split into two parts. The low six bits are a register address and the upper 26 bits are the payload. One system cycle after the last bit, the block raises a single write strobe for the addressed register. Address 63 has no register. A write to it only serves to collect the status word that is returned on the serial output.

The status word is shifted back to the controller during every transfer, least significant bit first. It is captured at the first bit of each word, so the value sent is consistent for the whole transfer. A ready flag marks the point where the block is waiting for the first bit of a new word. A synchronous reset lets the controller restore bit alignment if the two sides lose step.

Top module: `ser_cmd_slave`

## Requirements
- R1: The serial clock and data inputs are sampled only on an enable that fires once every OVS_DIV system cycles (default 8). Each sample passes through two synchroniser stages. One bit is taken for each rising edge seen in the sampled serial clock, and a level held steady across several enables produces no extra bits.
- R2: Command bits enter most significant bit first. After 32 bits, `wr_addr` equals word bits [5:0] and `wr_data` equals word bits [31:6].
- R3: The serial output returns the status word least significant bit first. After the k-th rising serial clock edge of a word (k counted from 0), `ser_dout` shows status bit k until the next rising edge.
- R4: `status_word` is captured at the first bit of a word. Later changes to it during the same word do not alter the bits shifted out.
- R5: When the 32nd bit arrives, exactly one bit of `wr_en` goes high for exactly one system cycle. That bit is the one indexed by the received address. At all other times `wr_en` is zero.
- R6: A word addressed to 63 (all six address bits set) produces no write strobe at all, but it still shifts out the full status word.
- R7: `ready` is 1 exactly when the bit counter is at zero. It drops after the first bit of a word and returns to 1 after the 32nd bit.
- R8: A synchronous reset (`rst` = 1 at a clock edge) clears the bit counter and the outputs. Afterwards `ready` is 1, `wr_en` is 0 and `ser_dout` is 0, even if the reset arrives in the middle of a word.
- R9: Consecutive words are independent. After a complete word or a reset, the next 32 bits form a new word with its own address, payload and freshly captured status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock from the controller |
| ser_din | input | 1 | Serial command data, MSB first |
| status_word | input | 32 | Word returned to the controller, LSB first |
| ser_dout | output | 1 | Serial status data |
| ready | output | 1 | High while waiting for the first bit of a word |
| wr_en | output | 64 | One-hot write strobe, one bit per address |
| wr_data | output | 26 | Payload field of the received word |
| wr_addr | output | 6 | Address field of the received word |

## Verification
Some properties are checked on every cycle. The write strobe is never more than one-hot and never lasts past one cycle. Address 63 never receives a strobe. Each strobe coincides with `ready` being high again. Reset always leaves the port idle with `ready` high.

Other behaviours depend on a whole transfer and only the directed scenarios can show them. These are the bit order in each direction, the field split, the capture of the status word at the first bit, and how the counter realigns after a reset in mid-word.

// File: rtl/ser_cmd_slave.sv
module ser_cmd_slave #(
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 6,
  parameter int OVS_DIV = 8,
  localparam int DATA_W = WORD_W - ADDR_W,
  localparam int NREG   = 1 << ADDR_W,
  localparam int CNT_W  = $clog2(WORD_W),
  localparam int DIV_W  = (OVS_DIV > 2) ? $clog2(OVS_DIV) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic [WORD_W-1:0] status_word,
  output logic              ser_dout,
  output logic              ready,
  output logic [NREG-1:0]   wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] wr_addr
);

  logic [DIV_W-1:0]  div_q;
  logic [2:0]        sck_q;
  logic [1:0]        din_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] stat_q;
  logic              dout_q;
  logic              valid_q;

  wire tick = (div_q == DIV_W'(OVS_DIV - 1));
  wire rise = tick && sck_q[1] && !sck_q[2];
  wire last = (bit_cnt == CNT_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sck_q <= '0;
      din_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        sck_q <= {sck_q[1:0], ser_clk};
        din_q <= {din_q[0], ser_din};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      shift_q <= '0;
      stat_q  <= '0;
      dout_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rise && last;
      if (rise) begin
        shift_q <= {shift_q[WORD_W-2:0], din_q[1]};
        bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == '0) begin
          stat_q <= status_word;
          dout_q <= status_word[0];
        end else begin
          dout_q <= stat_q[bit_cnt];
        end
      end
    end
  end

  assign ser_dout = dout_q;
  assign ready    = (bit_cnt == '0);
  assign wr_addr  = shift_q[ADDR_W-1:0];
  assign wr_data  = shift_q[WORD_W-1:ADDR_W];

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    if (g == NREG - 1) begin : g_rd
      assign wr_en[g] = 1'b0;
    end else begin : g_wr
      assign wr_en[g] = valid_q && (wr_addr == ADDR_W'(g));
    end
  end

endmodule

// File: rtl/ser_cmd_slave_chk.sv
module ser_cmd_slave_chk #(
  parameter int NREG = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            ready,
  input logic            ser_dout,
  input logic [NREG-1:0] wr_en
);

  p_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));

  p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) |=> (wr_en == '0));

  p_no_read_addr_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en[NREG-1]);

  p_ready_at_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) |-> ready);

  p_reset_idle_r8: assert property (@(posedge clk)
    rst |=> (ready && (wr_en == '0) && !ser_dout));

endmodule

bind ser_cmd_slave ser_cmd_slave_chk #(.NREG(NREG)) u_chk (
  .clk(clk), .rst(rst), .ready(ready), .ser_dout(ser_dout), .wr_en(wr_en)
);

// File: tb/ser_cmd_slave_tb.sv
`timescale 1ns/1ps
module ser_cmd_slave_tb;
  localparam int HALF = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic [31:0] status_word = '0;
  logic        ser_dout, ready;
  logic [63:0] wr_en;
  logic [25:0] wr_data;
  logic [5:0]  wr_addr;

  int checks = 0, errors = 0;
  int pulse_cnt = 0, pulse_idx = -1, multi_hot = 0;
  logic [25:0] pulse_data;
  bit done = 0;

  always #2 clk = ~clk;

  ser_cmd_slave u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_din(ser_din),
    .status_word(status_word), .ser_dout(ser_dout), .ready(ready),
    .wr_en(wr_en), .wr_data(wr_data), .wr_addr(wr_addr)
  );

  always @(negedge clk) begin
    if (wr_en != '0) begin
      pulse_cnt++;
      if ($countones(wr_en) != 1) multi_hot++;
      for (int i = 0; i < 64; i++) if (wr_en[i]) pulse_idx = i;
      pulse_data = wr_data;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    pulse_cnt = 0; pulse_idx = -1; multi_hot = 0;
  endtask

  task automatic send_bit(input logic b, output logic seen);
    ser_din = b;
    repeat (HALF / 2) @(negedge clk);
    ser_clk = 1'b1;
    repeat (HALF - 1) @(negedge clk);
    seen = ser_dout;
    @(negedge clk);
    ser_clk = 1'b0;
    repeat (HALF / 2) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] word, input logic [31:0] stat,
                      input bit disturb, output logic [31:0] got);
    status_word = stat;
    for (int k = 0; k < 32; k++) begin
      send_bit(word[31 - k], got[k]);
      if (disturb && k == 2) status_word = ~stat;
    end
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(ready === 1'b1, "R8 ready after reset", ready, 1);
    chk(wr_en === '0, "R8 wr_en after reset", wr_en, 0);
    chk(ser_dout === 1'b0, "R8 ser_dout after reset", ser_dout, 0);
  endtask

  task automatic t_write(input logic [5:0] a, input logic [25:0] d, input string tag);
    logic [31:0] got;
    clear_mon();
    xfer({d, a}, 32'h0, 0, got);
    chk(pulse_cnt == 1, {tag, " R5 one strobe"}, pulse_cnt, 1);
    chk(multi_hot == 0, {tag, " R5 one-hot"}, multi_hot, 0);
    chk(pulse_idx == int'(a), {tag, " R2 address field"}, pulse_idx, a);
    chk(pulse_data == d, {tag, " R2 data field"}, pulse_data, d);
    chk(ready === 1'b1, {tag, " R7 ready after word"}, ready, 1);
  endtask

  task automatic t_read_only();
    logic [31:0] got;
    clear_mon();
    xfer({26'h3ABCDEF, 6'h3F}, 32'hC0DE_5A17, 0, got);
    chk(pulse_cnt == 0, "R6 no strobe for address 63", pulse_cnt, 0);
    chk(got == 32'hC0DE_5A17, "R6 status still shifted out", got, 32'hC0DE_5A17);
  endtask

  task automatic t_status_order();
    logic [31:0] got;
    xfer({26'h0000123, 6'd7}, 32'h8000_0001, 0, got);
    chk(got == 32'h8000_0001, "R3 LSB first status", got, 32'h8000_0001);
    xfer({26'h0000456, 6'd8}, 32'h1234_5678, 0, got);
    chk(got == 32'h1234_5678, "R3 status pattern", got, 32'h1234_5678);
  endtask

  task automatic t_status_latch();
    logic [31:0] got;
    xfer({26'h0000789, 6'd9}, 32'hA5A5_0F0F, 1, got);
    chk(got == 32'hA5A5_0F0F, "R4 status captured at first bit", got, 32'hA5A5_0F0F);
    xfer({26'h000078A, 6'd9}, 32'h5A5A_F0F0, 0, got);
    chk(got == 32'h5A5A_F0F0, "R9 next word recaptures status", got, 32'h5A5A_F0F0);
  endtask

  task automatic t_midword_reset();
    logic seen;
    logic [31:0] junk;
    clear_mon();
    for (int k = 0; k < 10; k++) send_bit(k[0], seen);
    chk(ready === 1'b0, "R7 ready low mid-word", ready, 0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(ready === 1'b1, "R8 ready after mid-word reset", ready, 1);
    chk(ser_dout === 1'b0, "R8 ser_dout after mid-word reset", ser_dout, 0);
    chk(pulse_cnt == 0, "R8 no strobe from partial word", pulse_cnt, 0);
    repeat (HALF) @(negedge clk);
    t_write(6'd21, 26'h1555555, "R9 realigned");
    junk = '0;
  endtask

  task automatic t_slow_levels();
    logic seen;
    send_bit(1'b1, seen);
    repeat (20 * HALF) @(negedge clk);
    chk(ready === 1'b0, "R1 held level adds no bits", ready, 0);
    for (int k = 1; k < 32; k++) send_bit(1'b0, seen);
    repeat (HALF) @(negedge clk);
    chk(ready === 1'b1, "R1 exactly 32 edges per word", ready, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write(6'd5, 26'h2ABCDE1, "a5");
    t_write(6'd0, 26'h3FFFFFF, "a0");
    t_write(6'd62, 26'h0000001, "a62");
    t_read_only();
    t_status_order();
    t_status_latch();
    t_midword_reset();
    t_slow_levels();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule